// File: doc/BRIEF.md
# Integer Execute Unit with Condition Codes

This block is the integer datapath of a small RISC core. In one combinational pass it computes a 32-bit result from an operation code, a first operand (the value of the destination register) and a second operand (a register or an immediate). It also holds a 4-bit condition-code register. When the flag enable is high and the operation affects flags, this register loads the zero, carry, negative and overflow bits of the operation at the next clock edge.

The operations are add, subtract, compare, the three bitwise logic operations, logical left and right shifts, arithmetic right shift, rotate left, and two half-word loads. The half-word loads merge a 16-bit immediate into the upper or the lower half of the first operand. A write-enable output tells the register file whether the result should be written back: compare and the unused codes produce no write. The surrounding core supplies decode, the register file, branching and memory access.

Top module: `rsc_alu`

## Requirements
- R1: `cc_o` holds zero in bit 0, carry in bit 1, negative in bit 2 and overflow in bit 3, and it reads 0 while `rst_ni` is low.
- R2: `cc_o` changes only at a rising clock edge where `flag_en_i` is high and `op_i` is a flag-updating code (0 to 9). Load-half codes (10, 11) and the unused codes (12 to 15) never change it.
- R3: For every flag-updating code, the loaded zero bit is set exactly when the result is all zeros, and the loaded negative bit equals result bit 31.
- R4: Code 0 (add) gives A+B modulo 2^32. Carry is the carry out of bit 31. Overflow is set when A and B have the same sign and the result has the other sign. For example, 0x7FFFFFFF+1 sets overflow, and 0xFFFFFFFF+1 gives 0 with carry set.
- R5: Code 1 (subtract) gives A-B. Carry is set on a borrow, that is, when A<B unsigned. Overflow is set when A and B differ in sign and the result's sign differs from A. Code 2 (compare) loads the same flags, with `wr_en_o` low.
- R6: Codes 3, 4 and 5 give A AND B, A OR B and A XOR B, and clear carry and overflow.
- R7: For codes 6 (shift left), 7 (logical shift right) and 8 (arithmetic shift right), the shift amount is all 32 bits of B taken unsigned. An amount of zero returns A unchanged and clears carry.
- R8: For codes 6 and 7 with an amount of 1 to 31, carry is the last bit shifted out. An amount of exactly 32 gives 0 with carry equal to A[0] for a left shift or A[31] for a right shift. Any larger amount gives 0 with carry clear.
- R9: Code 8 fills with A[31]. An amount of 1 to 31 sets carry to the last bit shifted out. An amount of 32 or more gives 32 copies of A[31], with carry equal to A[31].
- R10: For codes 6 to 9, overflow is set exactly when result bit 31 differs from A[31].
- R11: Code 9 (rotate left) rotates A by B modulo 32, so bits leaving bit 31 re-enter at bit 0, and clears carry. For example, 1 rotated by 31 gives 0x80000000.
- R12: Code 10 gives {B[15:0], A[15:0]} and code 11 gives {A[31:16], B[15:0]}. B[31:16] is ignored.
- R13: `wr_en_o` is high for codes 0, 1 and 3 to 11. For codes 12 to 15, `result_o` is 0 and `wr_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | First operand (destination register value) |
| opb_i | input | 32 | Second operand or shift amount |
| flag_en_i | input | 1 | Load condition codes at the next edge |
| result_o | output | 32 | Combinational result |
| wr_en_o | output | 1 | Result should be written back |
| cc_o | output | 4 | Registered condition codes {V, N, C, Z} |

## Verification
The assertions check the following on every cycle:
- the condition-code register holds its value whenever no flag load is requested;
- the zero and negative bits match the result that was loaded;
- logic operations clear carry and overflow;
- shift overflow equals the sign change;
- a zero shift amount returns the operand;
- load-half keeps the untouched half;
- compare and unused codes never request a write.

The arithmetic carry and overflow values, the last-bit-out carry at amounts 1, 31, 32 and beyond, arithmetic fill, rotate wrap-around, and the sequence 0xDEAD then 0xBEEF building 0xDEADBEEF can only be shown by the directed scenarios with known operands.

// File: rtl/rsc_alu_pkg.sv
package rsc_alu_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned CC_W   = 4;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMP  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_LSL  = 4'd6,
    OP_LSR  = 4'd7,
    OP_ASR  = 4'd8,
    OP_ROL  = 4'd9,
    OP_LDHI = 4'd10,
    OP_LDLO = 4'd11,
    OP_R12  = 4'd12,
    OP_R13  = 4'd13,
    OP_R14  = 4'd14,
    OP_R15  = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROL = 2'd3
  } shift_e;

  typedef enum logic [2:0] {
    LG_AND  = 3'd0,
    LG_OR   = 3'd1,
    LG_XOR  = 3'd2,
    LG_LDHI = 3'd3,
    LG_LDLO = 3'd4
  } logic_e;

  // Packed MSB first: v is bit 3, z is bit 0.
  typedef struct packed {
    logic v;
    logic n;
    logic c;
    logic z;
  } cc_t;

endpackage

// File: rtl/rsc_alu_arith.sv
module rsc_alu_arith #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         carry_o,
  output logic         ovf_o
);

  logic [W-1:0] b_eff;
  logic [W:0]   sum;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    sum   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  end

  assign res_o   = sum[W-1:0];
  // Subtraction reports a borrow, which is the inverted carry out.
  assign carry_o = sub_i ? ~sum[W] : sum[W];
  assign ovf_o   = (a_i[W-1] == b_eff[W-1]) && (sum[W-1] != a_i[W-1]);

endmodule

// File: rtl/rsc_alu_shift.sv
module rsc_alu_shift
  import rsc_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] amt_i,
  input  shift_e       kind_i,
  output logic [W-1:0] res_o,
  output logic         carry_o
);

  localparam int unsigned SH_W = $clog2(W);
  localparam logic [W-1:0] FULL_AMT = W;

  logic [SH_W-1:0] sh;
  logic            big;
  logic            exact;
  logic [W:0]      lsl_ext;
  logic [W:0]      lsr_ext;
  logic signed [W:0] asr_src;
  logic [W:0]      asr_ext;
  logic [2*W-1:0]  rol_ext;

  always_comb begin
    sh      = amt_i[SH_W-1:0];
    big     = |amt_i[W-1:SH_W];
    exact   = (amt_i == FULL_AMT);
    // Extended words keep the last bit shifted out in the extra position.
    lsl_ext = {1'b0, a_i} << sh;
    lsr_ext = {a_i, 1'b0} >> sh;
    asr_src = {a_i, 1'b0};
    asr_ext = asr_src >>> sh;
    rol_ext = {a_i, a_i} << sh;
  end

  always_comb begin
    res_o   = '0;
    carry_o = 1'b0;
    unique case (kind_i)
      SH_LSL: begin
        if (big) begin
          res_o   = '0;
          carry_o = exact ? a_i[0] : 1'b0;
        end else begin
          res_o   = lsl_ext[W-1:0];
          carry_o = lsl_ext[W];
        end
      end
      SH_LSR: begin
        if (big) begin
          res_o   = '0;
          carry_o = exact ? a_i[W-1] : 1'b0;
        end else begin
          res_o   = lsr_ext[W:1];
          carry_o = lsr_ext[0];
        end
      end
      SH_ASR: begin
        if (big) begin
          res_o   = {W{a_i[W-1]}};
          carry_o = a_i[W-1];
        end else begin
          res_o   = asr_ext[W:1];
          carry_o = asr_ext[0];
        end
      end
      SH_ROL: begin
        res_o   = rol_ext[2*W-1:W];
        carry_o = 1'b0;
      end
      default: begin
        res_o   = '0;
        carry_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/rsc_alu_bitwise.sv
module rsc_alu_bitwise
  import rsc_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_e       kind_i,
  output logic [W-1:0] res_o
);

  localparam int unsigned HALF = W / 2;

  logic [W-1:0] and_v;
  logic [W-1:0] or_v;
  logic [W-1:0] xor_v;
  logic [W-1:0] hi_v;
  logic [W-1:0] lo_v;

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign and_v[g] = a_i[g] & b_i[g];
    assign or_v[g]  = a_i[g] | b_i[g];
    assign xor_v[g] = a_i[g] ^ b_i[g];
    if (g < HALF) begin : g_low
      assign hi_v[g] = a_i[g];
      assign lo_v[g] = b_i[g];
    end else begin : g_high
      assign hi_v[g] = b_i[g-HALF];
      assign lo_v[g] = a_i[g];
    end
  end

  always_comb begin
    unique case (kind_i)
      LG_AND:  res_o = and_v;
      LG_OR:   res_o = or_v;
      LG_XOR:  res_o = xor_v;
      LG_LDHI: res_o = hi_v;
      LG_LDLO: res_o = lo_v;
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/rsc_alu.sv
module rsc_alu
  import rsc_alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    op_i,
  input  logic [W-1:0]  opa_i,
  input  logic [W-1:0]  opb_i,
  input  logic          flag_en_i,
  output logic [W-1:0]  result_o,
  output logic          wr_en_o,
  output logic [CC_W-1:0] cc_o
);

  alu_op_e      op;
  logic         ar_sub;
  logic [W-1:0] ar_res;
  logic         ar_carry;
  logic         ar_ovf;
  shift_e       sh_kind;
  logic [W-1:0] sh_res;
  logic         sh_carry;
  logic_e       lg_kind;
  logic [W-1:0] lg_res;

  logic [W-1:0] res_d;
  logic         upd_d;
  logic         wr_d;
  cc_t          cc_d;
  cc_t          cc_q;
  logic         cc_load;

  assign op = alu_op_e'(op_i);

  // Decode into unit controls.
  always_comb begin
    ar_sub  = (op == OP_SUB) || (op == OP_CMP);
    sh_kind = SH_LSL;
    lg_kind = LG_AND;
    unique case (op)
      OP_LSR:  sh_kind = SH_LSR;
      OP_ASR:  sh_kind = SH_ASR;
      OP_ROL:  sh_kind = SH_ROL;
      default: sh_kind = SH_LSL;
    endcase
    unique case (op)
      OP_OR:   lg_kind = LG_OR;
      OP_XOR:  lg_kind = LG_XOR;
      OP_LDHI: lg_kind = LG_LDHI;
      OP_LDLO: lg_kind = LG_LDLO;
      default: lg_kind = LG_AND;
    endcase
  end

  rsc_alu_arith #(.W(W)) u_arith (
    .a_i     (opa_i),
    .b_i     (opb_i),
    .sub_i   (ar_sub),
    .res_o   (ar_res),
    .carry_o (ar_carry),
    .ovf_o   (ar_ovf)
  );

  rsc_alu_shift #(.W(W)) u_shift (
    .a_i     (opa_i),
    .amt_i   (opb_i),
    .kind_i  (sh_kind),
    .res_o   (sh_res),
    .carry_o (sh_carry)
  );

  rsc_alu_bitwise #(.W(W)) u_bitwise (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .kind_i (lg_kind),
    .res_o  (lg_res)
  );

  // Result select and next condition codes.
  always_comb begin
    res_d  = '0;
    upd_d  = 1'b0;
    wr_d   = 1'b0;
    cc_d   = cc_q;
    unique case (op)
      OP_ADD, OP_SUB, OP_CMP: begin
        res_d  = ar_res;
        upd_d  = 1'b1;
        wr_d   = (op != OP_CMP);
        cc_d.c = ar_carry;
        cc_d.v = ar_ovf;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_d  = lg_res;
        upd_d  = 1'b1;
        wr_d   = 1'b1;
        cc_d.c = 1'b0;
        cc_d.v = 1'b0;
      end
      OP_LSL, OP_LSR, OP_ASR, OP_ROL: begin
        res_d  = sh_res;
        upd_d  = 1'b1;
        wr_d   = 1'b1;
        cc_d.c = sh_carry;
        cc_d.v = sh_res[W-1] ^ opa_i[W-1];
      end
      OP_LDHI, OP_LDLO: begin
        res_d = lg_res;
        wr_d  = 1'b1;
      end
      default: begin
        res_d = '0;
        wr_d  = 1'b0;
      end
    endcase
    if (upd_d) begin
      cc_d.z = (res_d == '0);
      cc_d.n = res_d[W-1];
    end
  end

  assign cc_load = flag_en_i & upd_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_q <= '0;
    end else if (cc_load) begin
      cc_q <= cc_d;
    end
  end

  assign result_o = res_d;
  assign wr_en_o  = wr_d;
  assign cc_o     = cc_q;

endmodule

// File: rtl/rsc_alu_chk.sv
module rsc_alu_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [3:0]  op_i,
  input logic [31:0] opa_i,
  input logic [31:0] opb_i,
  input logic        flag_en_i,
  input logic [31:0] result_o,
  input logic        wr_en_o,
  input logic [3:0]  cc_o
);

  logic upd;
  logic lg_op;
  logic sh_op;
  logic rot_or_sh;

  assign upd       = (op_i <= 4'd9);
  assign lg_op     = (op_i >= 4'd3) && (op_i <= 4'd5);
  assign sh_op     = (op_i >= 4'd6) && (op_i <= 4'd8);
  assign rot_or_sh = (op_i >= 4'd6) && (op_i <= 4'd9);

  always_comb begin
    if (!rst_ni) begin
      assert_reset_zero_R1: assert (cc_o == 4'd0);
    end
  end

  assert_cc_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flag_en_i && upd) |=> $stable(cc_o));

  assert_zero_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && upd) |=> (cc_o[0] == ($past(result_o) == 32'd0)));

  assert_neg_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && upd) |=> (cc_o[2] == $past(result_o[31])));

  assert_cmp_nowrite_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd2) |-> !wr_en_o);

  assert_logic_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && lg_op) |=> (cc_o[1] == 1'b0 && cc_o[3] == 1'b0));

  assert_shift_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_op && opb_i == 32'd0) |-> (result_o == opa_i));

  assert_shift_ovf_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && rot_or_sh) |=> (cc_o[3] == ($past(result_o[31]) ^ $past(opa_i[31]))));

  assert_ldhi_keep_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd10) |-> (result_o[15:0] == opa_i[15:0]));

  assert_ldlo_keep_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd11) |-> (result_o[31:16] == opa_i[31:16]));

  assert_unused_code_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 4'd12) |-> (result_o == 32'd0 && !wr_en_o));

endmodule

bind rsc_alu rsc_alu_chk u_chk (.*);

// File: tb/rsc_alu_tb.sv
`timescale 1ns/1ps
module rsc_alu_tb;

  logic        clk;
  logic        rst_n;
  logic [3:0]  op;
  logic [31:0] opa;
  logic [31:0] opb;
  logic        fen;
  logic [31:0] res;
  logic        wr;
  logic [3:0]  cc;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  rsc_alu u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .op_i      (op),
    .opa_i     (opa),
    .opb_i     (opb),
    .flag_en_i (fen),
    .result_o  (res),
    .wr_en_o   (wr),
    .cc_o      (cc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one operation, check comb outputs, then the registered flags.
  task automatic step(input logic [3:0] o, input logic [31:0] a,
                      input logic [31:0] b, input logic en,
                      input logic [31:0] exp_res, input logic exp_wr,
                      input logic [3:0] exp_cc, input string tag);
    @(negedge clk);
    op = o; opa = a; opb = b; fen = en;
    #1;
    chk(res === exp_res, {tag, " result"}, res, exp_res);
    chk(wr === exp_wr, {tag, " wr_en"}, {31'd0, wr}, {31'd0, exp_wr});
    @(posedge clk);
    #1;
    chk(cc === exp_cc, {tag, " cc"}, {28'd0, cc}, {28'd0, exp_cc});
  endtask

  task automatic t_reset;
    #1;
    chk(cc === 4'h0, "R1 reset cc", {28'd0, cc}, 32'd0);
  endtask

  task automatic t_add;
    step(4'd0, 32'h7FFFFFFF, 32'd1, 1'b1, 32'h80000000, 1'b1, 4'hC, "R4 add ovf");
    step(4'd0, 32'hFFFFFFFF, 32'd1, 1'b1, 32'h00000000, 1'b1, 4'h3, "R4 add carry R3");
  endtask

  task automatic t_sub_cmp;
    step(4'd1, 32'h80000000, 32'd1, 1'b1, 32'h7FFFFFFF, 1'b1, 4'h8, "R5 sub ovf");
    step(4'd1, 32'h00000000, 32'd1, 1'b1, 32'hFFFFFFFF, 1'b1, 4'h6, "R5 sub borrow");
    step(4'd2, 32'd5, 32'd5, 1'b1, 32'h00000000, 1'b0, 4'h1, "R5 cmp equal");
    step(4'd2, 32'd3, 32'd5, 1'b1, 32'hFFFFFFFE, 1'b0, 4'h6, "R5 cmp less");
    step(4'd1, 32'd5, 32'd3, 1'b1, 32'd2, 1'b1, 4'h0, "R5 sub plain");
  endtask

  task automatic t_logic;
    step(4'd0, 32'h80000000, 32'h80000000, 1'b1, 32'd0, 1'b1, 4'hB, "R4 add neg ovf");
    step(4'd3, 32'h74, 32'hFF, 1'b1, 32'h74, 1'b1, 4'h0, "R6 and clears");
    step(4'd4, 32'h3500, 32'h74, 1'b1, 32'h3574, 1'b1, 4'h0, "R6 or");
    step(4'd5, 32'hA5A5A5A5, 32'hA5A5A5A5, 1'b1, 32'd0, 1'b1, 4'h1, "R6 xor zero");
    step(4'd3, 32'hF0000000, 32'h80000000, 1'b1, 32'h80000000, 1'b1, 4'h4, "R6 and neg");
  endtask

  task automatic t_shift_zero;
    step(4'd7, 32'hFFFFFFFF, 32'd0, 1'b1, 32'hFFFFFFFF, 1'b1, 4'h4, "R7 lsr 0");
    step(4'd0, 32'hFFFFFFFF, 32'd1, 1'b1, 32'd0, 1'b1, 4'h3, "R4 set carry");
    step(4'd6, 32'h12345678, 32'd0, 1'b1, 32'h12345678, 1'b1, 4'h0, "R7 lsl 0");
    step(4'd8, 32'hFFFFFFFF, 32'd0, 1'b1, 32'hFFFFFFFF, 1'b1, 4'h4, "R7 asr 0");
  endtask

  task automatic t_lsr;
    step(4'd7, 32'hFFFFFFFF, 32'd1, 1'b1, 32'h7FFFFFFF, 1'b1, 4'hA, "R8 lsr 1");
    step(4'd7, 32'h7FFFFFFF, 32'd31, 1'b1, 32'd0, 1'b1, 4'h3, "R8 lsr 31");
    step(4'd7, 32'h00000000, 32'd1, 1'b1, 32'd0, 1'b1, 4'h1, "R8 lsr zero op");
    step(4'd7, 32'hFFFFFFFF, 32'd32, 1'b1, 32'd0, 1'b1, 4'hB, "R8 lsr 32");
    step(4'd7, 32'hFFFFFFFF, 32'd40, 1'b1, 32'd0, 1'b1, 4'h9, "R8 lsr 40");
    step(4'd7, 32'h80000000, 32'd1, 1'b1, 32'h40000000, 1'b1, 4'h8, "R10 lsr sign");
  endtask

  task automatic t_lsl;
    step(4'd6, 32'h40000000, 32'd1, 1'b1, 32'h80000000, 1'b1, 4'hC, "R10 lsl into sign");
    step(4'd6, 32'h80000000, 32'd1, 1'b1, 32'd0, 1'b1, 4'hB, "R8 lsl out of sign");
    step(4'd6, 32'h35, 32'd8, 1'b1, 32'h3500, 1'b1, 4'h0, "R8 lsl 8");
    step(4'd6, 32'd1, 32'd32, 1'b1, 32'd0, 1'b1, 4'h3, "R8 lsl 32");
    step(4'd6, 32'd3, 32'd33, 1'b1, 32'd0, 1'b1, 4'h1, "R8 lsl 33");
  endtask

  task automatic t_asr;
    step(4'd8, 32'hFFFFFFFF, 32'd32, 1'b1, 32'hFFFFFFFF, 1'b1, 4'h6, "R9 asr 32");
    step(4'd8, 32'hFFFFFFFF, 32'd1, 1'b1, 32'hFFFFFFFF, 1'b1, 4'h6, "R9 asr 1");
    step(4'd8, 32'h80000000, 32'd1, 1'b1, 32'hC0000000, 1'b1, 4'h4, "R9 asr fill");
    step(4'd8, 32'h80000000, 32'd31, 1'b1, 32'hFFFFFFFF, 1'b1, 4'h4, "R9 asr 31");
    step(4'd8, 32'h7FFFFFFF, 32'd100, 1'b1, 32'd0, 1'b1, 4'h1, "R9 asr big pos");
    step(4'd8, 32'h6, 32'd2, 1'b1, 32'd1, 1'b1, 4'h2, "R9 asr carry");
  endtask

  task automatic t_rotate;
    step(4'd9, 32'd1, 32'd31, 1'b1, 32'h80000000, 1'b1, 4'hC, "R11 rol 31");
    step(4'd9, 32'h80000001, 32'd4, 1'b1, 32'h00000018, 1'b1, 4'h8, "R11 rol wrap");
    step(4'd9, 32'h12345678, 32'd32, 1'b1, 32'h12345678, 1'b1, 4'h0, "R11 rol 32");
    step(4'd9, 32'h12345678, 32'd36, 1'b1, 32'h23456781, 1'b1, 4'h0, "R11 rol 36");
  endtask

  task automatic t_load_half;
    step(4'd0, 32'hFFFFFFFF, 32'd1, 1'b1, 32'd0, 1'b1, 4'h3, "R4 preset cc");
    step(4'd10, 32'h12345678, 32'hABCDDEAD, 1'b1, 32'hDEAD5678, 1'b1, 4'h3, "R12 ldhi R2");
    step(4'd11, 32'hDEAD5678, 32'h0000BEEF, 1'b1, 32'hDEADBEEF, 1'b1, 4'h3, "R12 ldlo R2");
  endtask

  task automatic t_flag_hold;
    step(4'd0, 32'h7FFFFFFF, 32'd1, 1'b0, 32'h80000000, 1'b1, 4'h3, "R2 add no en");
    step(4'd1, 32'd0, 32'd0, 1'b0, 32'd0, 1'b1, 4'h3, "R2 sub no en");
  endtask

  task automatic t_reserved;
    step(4'd12, 32'h1234, 32'd5, 1'b1, 32'd0, 1'b0, 4'h3, "R13 code 12");
    step(4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 32'd0, 1'b0, 4'h3, "R13 code 15");
  endtask

  initial begin
    rst_n = 1'b0;
    op = 4'd0; opa = '0; opb = '0; fen = 1'b0;
    repeat (3) @(posedge clk);
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    t_add;
    t_sub_cmp;
    t_logic;
    t_shift_zero;
    t_lsr;
    t_lsl;
    t_asr;
    t_rotate;
    t_load_half;
    t_flag_hold;
    t_reserved;
    @(negedge clk);
    fen = 1'b0;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule